// File: doc/BRIEF.md
# Accumulator Processor Control Sequencer

A single-accumulator processor core built around a timing-state controller. Each instruction is one 16-bit word: an indirect flag in the top bit, a three-bit operation code below it, and a twelve-bit address field. The controller fetches the word, then takes a second memory pass only when the indirect flag is set. It then executes the operation and, before the next fetch, spends one state checking whether an interrupt should be taken.

The core drives an external synchronous memory of up to 4096 words of 16 bits. The address it presents is always the contents of its 12-bit address register. Read data is returned one clock after the address is presented, and a write is committed on the clock edge at which the write strobe is high.

The registers are the following:
- a 12-bit program counter and a 12-bit address register;
- 16-bit instruction, data, temporary and accumulator registers, plus a carry bit;
- an 8-bit input holding register and an 8-bit output holding register, each with a flag.

Operation code 7 does not touch memory. For it, the address field selects one register or I/O action. A halt action freezes the core until reset.

Top module: `acc_seq_core`

## Requirements
- R1: While rst_n is low at a clock edge, the core returns to the fetch start state with PC, address register, accumulator and carry at zero. The input flag and the interrupt enable are 0, the output flag is 1, halted is 0, mem_wr is 0 and mem_addr is 0.
- R2: Instruction bit 15 is the indirect flag, bits 14:12 the operation and bits 11:0 the address. The operation codes are 0 AND, 1 ADD, 2 LDA, 3 STA, 4 BUN, 5 BSA, 6 ISZ and 7 register/IO. The cost of each instruction, counting the interrupt-check state, is as follows:
  - a direct memory instruction takes 7 cycles;
  - the indirect flag adds 2 cycles;
  - ISZ adds 1 cycle;
  - a register/IO instruction takes 5 cycles;
  - HLT reaches the halted state 4 cycles after its fetch begins.
- R3: With bit 15 set on operation codes 0 to 6, the effective address is bits 11:0 of the memory word at the address field. Upper bits of that pointer word are ignored.
- R4: AND leaves AC & M[ea] in AC, LDA loads AC with M[ea], and STA writes AC to M[ea].
- R5: ADD leaves the low 16 bits of AC + M[ea] in AC and the carry-out in the carry bit. Register action SZE (address bit 6) skips the next instruction when the carry bit is 0.
- R6: BUN loads PC with the effective address. BSA stores the return address at M[ea] and continues at ea+1, so an indirect BUN through M[ea] returns to the instruction after the BSA.
- R7: ISZ writes M[ea]+1 back to M[ea] and skips the next instruction when the written value is zero.
- R8: Register/IO actions are selected by address bit: 11 CLA, 10 CLE, 9 CMA, 8 INC, 7 SZA (skip if AC is zero), 6 SZE, 5 SKI, 4 INP, 3 OUT, 2 ION, 1 IOF, 0 HLT. When several bits are set, only the highest one acts.
- R9: The input and output holding registers behave as follows:
  - an in_load pulse captures in_data and sets in_flag;
  - SKI skips the next instruction when in_flag is 1;
  - INP copies the input byte into AC bits 7:0 and clears in_flag;
  - OUT copies AC bits 7:0 to out_data and clears out_flag;
  - an out_done pulse sets out_flag.
- R10: In the check state after an instruction, if the interrupt enable is 1 and either flag is 1, the core does three things: it writes the PC of the next instruction to M[0], loads PC with 1 and clears the enable. An ION takes effect at the check that directly follows it.
- R11: After HLT, the core makes no memory writes and holds mem_addr. It ignores in_load and out_done, leaving the flags unchanged, until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_addr | output | 12 | Memory word address (address register) |
| mem_wr | output | 1 | Write strobe, committed at the clock edge |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, word at the address presented one clock earlier |
| in_data | input | 8 | Byte from the input device |
| in_load | input | 1 | One-cycle pulse: capture in_data, set in_flag |
| in_flag | output | 1 | Input byte waiting |
| out_data | output | 8 | Output holding register |
| out_done | input | 1 | One-cycle pulse: output device ready again |
| out_flag | output | 1 | Output device ready for a byte |
| int_en | output | 1 | Interrupt enable |
| halted | output | 1 | Core stopped by HLT |

## Verification
The bench builds the core with the package defaults: 16-bit words, a 12-bit address and 8-bit I/O. It models a 256-word memory, so every program and data word sits in the low address byte.

With that size, each arithmetic and logic operation can be swept over every pairing of six edge operands: zero, one, the two sign boundaries, all ones and a mixed pattern. ISZ and SZA are swept across the wrap-to-zero point. Cycle counts for direct, indirect, ISZ, register and halt instructions are predicted by counting controller states.

// File: rtl/acc_seq_pkg.sv
// Shared widths, controller states, operation codes and register/IO action bit
// positions. Assumes WORD_W == 1 + OPC_W + ADDR_W (indirect flag, opcode, address).
package acc_seq_pkg;
    parameter int WORD_W = 16;
    parameter int ADDR_W = 12;
    parameter int IO_W   = 8;
    localparam int OPC_W   = 3;
    localparam int OPC_LSB = ADDR_W;
    localparam int IND_BIT = ADDR_W + OPC_W;

    typedef enum logic [3:0] {
        ST_F0, ST_F1, ST_F2, ST_DEC, ST_IW, ST_IND, ST_XW,
        ST_EX, ST_EX2, ST_CHK, ST_INT0, ST_INT1, ST_HALT
    } state_t;

    typedef enum logic [OPC_W-1:0] {
        OP_AND = 3'd0, OP_ADD = 3'd1, OP_LDA = 3'd2, OP_STA = 3'd3,
        OP_BUN = 3'd4, OP_BSA = 3'd5, OP_ISZ = 3'd6, OP_REG = 3'd7
    } opc_t;

    localparam int SB_HLT = 0;
    localparam int SB_IOF = 1;
    localparam int SB_ION = 2;
    localparam int SB_OUT = 3;
    localparam int SB_INP = 4;
    localparam int SB_SKI = 5;
    localparam int SB_SZE = 6;
    localparam int SB_SZA = 7;
    localparam int SB_INC = 8;
    localparam int SB_CMA = 9;
    localparam int SB_CLE = 10;
    localparam int SB_CLA = 11;
endpackage

// File: rtl/acc_seq_fsm.sv
// Timing-state controller: fetch (3 states), decode, optional indirect pass,
// execute, interrupt check, interrupt entry, halt.
// Assumes memory read data is valid one clock after the address register changes.
module acc_seq_fsm
    import acc_seq_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   ir_ind,
    input  opc_t   ir_opc,
    input  logic   hlt_sel,
    input  logic   int_req,
    output state_t state
);
    state_t nxt;

    // Next-state selection from the current state and the decoded instruction.
    always_comb begin
        nxt = state;
        case (state)
            ST_F0:   nxt = ST_F1;
            ST_F1:   nxt = ST_F2;
            ST_F2:   nxt = ST_DEC;
            ST_DEC: begin
                if (ir_opc == OP_REG) nxt = hlt_sel ? ST_HALT : ST_CHK;
                else if (ir_ind)      nxt = ST_IW;
                else                  nxt = ST_XW;
            end
            ST_IW:   nxt = ST_IND;
            ST_IND:  nxt = ST_XW;
            ST_XW:   nxt = ST_EX;
            ST_EX:   nxt = (ir_opc == OP_ISZ) ? ST_EX2 : ST_CHK;
            ST_EX2:  nxt = ST_CHK;
            ST_CHK:  nxt = int_req ? ST_INT0 : ST_F0;
            ST_INT0: nxt = ST_INT1;
            ST_INT1: nxt = ST_F0;
            ST_HALT: nxt = ST_HALT;
            default: nxt = ST_F0;
        endcase
    end

    // State register with synchronous reset to the fetch start.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_F0;
        else        state <= nxt;
    end

    AST_IND_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IND) |-> ir_ind);                                       // R3
    AST_HALT_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HALT) |=> (state == ST_HALT));                          // R11
endmodule

// File: rtl/acc_seq_dp.sv
// Register file and transfers: PC, address, instruction, data, temporary,
// accumulator and carry. Drives the memory port from the address register.
// Assumes sub_sel is one-hot or zero and only nonzero during a register/IO decode.
module acc_seq_dp
    import acc_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  state_t            state,
    input  logic [WORD_W-1:0] rdata,
    input  logic [ADDR_W-1:0] sub_sel,
    input  logic [IO_W-1:0]   in_reg,
    input  logic              in_flag,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_wr,
    output logic [WORD_W-1:0] mem_wdata,
    output logic [WORD_W-1:0] ir,
    output logic [IO_W-1:0]   ac_lo
);
    localparam int PAD_W = WORD_W - ADDR_W;

    logic [ADDR_W-1:0] pc, ar;
    logic [WORD_W-1:0] dr, ac, tr;
    logic              e;
    logic [WORD_W:0]   sum;
    logic              reg_go, skip;
    opc_t              opc;

    assign opc      = opc_t'(ir[IND_BIT-1:OPC_LSB]);
    assign reg_go   = (state == ST_DEC) && (opc == OP_REG);
    assign sum      = {1'b0, ac} + {1'b0, rdata};
    assign mem_addr = ar;
    assign ac_lo    = ac[IO_W-1:0];

    // Skip condition for the register/IO skip actions.
    always_comb begin
        skip = reg_go && ((sub_sel[SB_SZA] && (ac == '0)) ||
                          (sub_sel[SB_SZE] && !e) ||
                          (sub_sel[SB_SKI] && in_flag));
    end

    // Program counter, address, instruction and temporary register transfers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc <= '0; ar <= '0; ir <= '0; tr <= '0;
        end else begin
            case (state)
                ST_F0:   ar <= pc;
                ST_F2:   begin ir <= rdata; pc <= pc + ADDR_W'(1); end
                ST_DEC:  begin
                    if (!reg_go)   ar <= ir[ADDR_W-1:0];
                    else if (skip) pc <= pc + ADDR_W'(1);
                end
                ST_IND:  ar <= rdata[ADDR_W-1:0];
                ST_EX: begin
                    if (opc == OP_BUN)      pc <= ar;
                    else if (opc == OP_BSA) pc <= ar + ADDR_W'(1);
                end
                ST_EX2:  if (dr == '0) pc <= pc + ADDR_W'(1);
                ST_INT0: begin ar <= '0; tr <= {{PAD_W{1'b0}}, pc}; end
                ST_INT1: pc <= ADDR_W'(1);
                default: ;
            endcase
        end
    end

    // Accumulator, carry and data register updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ac <= '0; e <= 1'b0; dr <= '0;
        end else if (reg_go) begin
            if (sub_sel[SB_CLA]) ac <= '0;
            if (sub_sel[SB_CLE]) e  <= 1'b0;
            if (sub_sel[SB_CMA]) ac <= ~ac;
            if (sub_sel[SB_INC]) ac <= ac + WORD_W'(1);
            if (sub_sel[SB_INP]) ac[IO_W-1:0] <= in_reg;
        end else if (state == ST_EX) begin
            case (opc)
                OP_AND:  ac <= ac & rdata;
                OP_ADD:  {e, ac} <= sum;
                OP_LDA:  ac <= rdata;
                OP_ISZ:  dr <= rdata + WORD_W'(1);
                default: ;
            endcase
        end
    end

    // Memory write strobe and write-data selection.
    always_comb begin
        mem_wr    = 1'b0;
        mem_wdata = ac;
        case (state)
            ST_EX: begin
                if (opc == OP_STA) mem_wr = 1'b1;
                else if (opc == OP_BSA) begin
                    mem_wr    = 1'b1;
                    mem_wdata = {{PAD_W{1'b0}}, pc};
                end
            end
            ST_EX2:  begin mem_wr = 1'b1; mem_wdata = dr; end
            ST_INT1: begin mem_wr = 1'b1; mem_wdata = tr; end
            default: ;
        endcase
    end

    AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_F2) |-> (pc == $past(pc) + ADDR_W'(1)));        // R2
    AST_IR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) != ST_F2) |-> $stable(ir));                           // R2
    AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_HALT) && ($past(state) == ST_HALT)) |->
        ($stable(ac) && $stable(pc) && $stable(ar)));                       // R11
    AST_VEC_SAVE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_INT1) |-> (mem_wr && (mem_addr == '0)));               // R10
endmodule

// File: rtl/acc_seq_io.sv
// Input/output holding registers, their flags, and the interrupt enable.
// Assumes external pulses last one clock; all updates are frozen while halted.
module acc_seq_io
    import acc_seq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            halted,
    input  logic [IO_W-1:0] in_data,
    input  logic            in_load,
    input  logic            out_done,
    input  logic            do_inp,
    input  logic            do_out,
    input  logic            do_ion,
    input  logic            do_iof,
    input  logic            int_ack,
    input  logic [IO_W-1:0] ac_lo,
    output logic [IO_W-1:0] in_reg,
    output logic            in_flag,
    output logic [IO_W-1:0] out_reg,
    output logic            out_flag,
    output logic            ien,
    output logic            int_req
);
    assign int_req = ien && (in_flag || out_flag);

    // Flag, holding register and enable updates; new input and OUT take precedence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_reg <= '0; in_flag <= 1'b0;
            out_reg <= '0; out_flag <= 1'b1;
            ien <= 1'b0;
        end else if (!halted) begin
            if (in_load) begin
                in_reg  <= in_data;
                in_flag <= 1'b1;
            end else if (do_inp) begin
                in_flag <= 1'b0;
            end
            if (do_out) begin
                out_reg  <= ac_lo;
                out_flag <= 1'b0;
            end else if (out_done) begin
                out_flag <= 1'b1;
            end
            if (int_ack)     ien <= 1'b0;
            else if (do_ion) ien <= 1'b1;
            else if (do_iof) ien <= 1'b0;
        end
    end

    AST_IEN_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        $past(int_ack) |-> !ien);                                            // R10
    AST_OUT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $past(do_out) |-> ((out_reg == $past(ac_lo)) && !out_flag));         // R9
endmodule

// File: rtl/acc_seq_core.sv
// Top of the accumulator processor: wires controller, datapath and I/O, and
// decodes the register/IO action (highest set address bit wins).
// Assumes a synchronous memory returning M[mem_addr] one clock after it is presented.
module acc_seq_core
    import acc_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_wr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic [IO_W-1:0]   in_data,
    input  logic              in_load,
    output logic              in_flag,
    output logic [IO_W-1:0]   out_data,
    input  logic              out_done,
    output logic              out_flag,
    output logic              int_en,
    output logic              halted
);
    state_t            state;
    logic [WORD_W-1:0] ir;
    logic [ADDR_W-1:0] sub_sel, sub_go;
    logic [IO_W-1:0]   in_reg, ac_lo;
    logic              int_req, reg_go;
    opc_t              opc;

    assign opc    = opc_t'(ir[IND_BIT-1:OPC_LSB]);
    assign reg_go = (state == ST_DEC) && (opc == OP_REG);
    assign sub_go = reg_go ? sub_sel : '0;
    assign halted = (state == ST_HALT);

    // Priority pick of the highest set address bit as the register/IO action.
    always_comb begin
        sub_sel = '0;
        for (int b = 0; b < ADDR_W; b++) begin
            if (ir[b]) sub_sel = ADDR_W'(1) << b;
        end
    end

    acc_seq_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .ir_ind  (ir[IND_BIT]),
        .ir_opc  (opc),
        .hlt_sel (sub_sel[SB_HLT]),
        .int_req (int_req),
        .state   (state)
    );

    acc_seq_dp u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .state     (state),
        .rdata     (mem_rdata),
        .sub_sel   (sub_go),
        .in_reg    (in_reg),
        .in_flag   (in_flag),
        .mem_addr  (mem_addr),
        .mem_wr    (mem_wr),
        .mem_wdata (mem_wdata),
        .ir        (ir),
        .ac_lo     (ac_lo)
    );

    acc_seq_io u_io (
        .clk      (clk),
        .rst_n    (rst_n),
        .halted   (halted),
        .in_data  (in_data),
        .in_load  (in_load),
        .out_done (out_done),
        .do_inp   (sub_go[SB_INP]),
        .do_out   (sub_go[SB_OUT]),
        .do_ion   (sub_go[SB_ION]),
        .do_iof   (sub_go[SB_IOF]),
        .int_ack  (state == ST_INT1),
        .ac_lo    (ac_lo),
        .in_reg   (in_reg),
        .in_flag  (in_flag),
        .out_reg  (out_data),
        .out_flag (out_flag),
        .ien      (int_en),
        .int_req  (int_req)
    );

    AST_WR_NOT_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !mem_wr);                                                 // R11
endmodule

// File: tb/tb_acc_seq_core.sv
`timescale 1ns/1ps
module tb_acc_seq_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] mem_addr;
    logic        mem_wr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata = 16'h0;
    logic [7:0]  in_data = 8'h0;
    logic        in_load = 1'b0;
    logic        in_flag;
    logic [7:0]  out_data;
    logic        out_done = 1'b0;
    logic        out_flag;
    logic        int_en;
    logic        halted;

    logic [15:0] mem [0:255];
    logic        ld_en = 1'b0;
    logic [7:0]  ld_addr = 8'h0;
    logic [15:0] ld_data = 16'h0;

    int n_chk = 0;
    int n_fail = 0;
    int cyc_all = 0;

    acc_seq_core dut (
        .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_wr(mem_wr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .in_data(in_data),
        .in_load(in_load), .in_flag(in_flag), .out_data(out_data),
        .out_done(out_done), .out_flag(out_flag), .int_en(int_en), .halted(halted)
    );

    always #2.5 clk = ~clk;

    // Synchronous memory model with a bench load port.
    always @(posedge clk) begin
        if (ld_en) mem[ld_addr] <= ld_data;
        else if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
        mem_rdata <= mem[mem_addr[7:0]];
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc_all++;
        if (cyc_all > 190000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=<190000", cyc_all);
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic poke(input logic [7:0] a, input logic [15:0] d);
        ld_en = 1'b1; ld_addr = a; ld_data = d;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic hold_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        for (int i = 0; i < 256; i++) poke(8'(i), 16'h0);
    endtask

    task automatic wait_halt(output int cyc);
        cyc = 0;
        while (!halted && cyc < 3000) begin
            @(negedge clk);
            cyc++;
        end
        if (!halted) begin
            n_chk++; n_fail++;
            $display("FAIL run-to-halt actual=%0d expected=halt", cyc);
        end
    endtask

    task automatic run_prog(output int cyc);
        rst_n = 1'b1;
        wait_halt(cyc);
    endtask

    logic [15:0] edge_v [6] = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF, 16'h1234};
    logic [15:0] wrap_v [5] = '{16'hFFFF, 16'hFFFE, 16'h0000, 16'h7FFF, 16'h1234};

    initial begin
        int cyc;
        logic [16:0] s;
        logic [11:0] held;

        // R1: reset state
        hold_reset();
        chk("R1 halted", {15'd0, halted}, 16'd0);
        chk("R1 int_en", {15'd0, int_en}, 16'd0);
        chk("R1 out_flag", {15'd0, out_flag}, 16'd1);
        chk("R1 in_flag", {15'd0, in_flag}, 16'd0);
        chk("R1 mem_wr", {15'd0, mem_wr}, 16'd0);
        chk("R1 mem_addr", {4'd0, mem_addr}, 16'd0);

        // R2: state counts 7 + 9 + 8 + 5 + 4 = 33
        hold_reset();
        poke(8'h00, 16'h2040); poke(8'h01, 16'hA041); poke(8'h02, 16'h6042);
        poke(8'h03, 16'h7800); poke(8'h04, 16'h7001);
        poke(8'h41, 16'h0043); poke(8'h42, 16'h0005);
        run_prog(cyc);
        chk("R2 cycle count", 16'(cyc), 16'd33);
        chk("R7 ISZ no-skip value", mem[8'h42], 16'h0006);

        // R4 R5 R8: operand sweep
        for (int i = 0; i < 6; i++) begin
            for (int j = 0; j < 6; j++) begin
                hold_reset();
                poke(8'h00, 16'h2040); poke(8'h01, 16'h1041); poke(8'h02, 16'h3042);
                poke(8'h03, 16'h7800); poke(8'h04, 16'h7040); poke(8'h05, 16'h7100);
                poke(8'h06, 16'h3043); poke(8'h07, 16'h2040); poke(8'h08, 16'h0041);
                poke(8'h09, 16'h3044); poke(8'h0A, 16'h7200); poke(8'h0B, 16'h3045);
                poke(8'h0C, 16'h7900); poke(8'h0D, 16'h3046); poke(8'h0E, 16'h7001);
                poke(8'h40, edge_v[i]); poke(8'h41, edge_v[j]); poke(8'h46, 16'hFFFF);
                run_prog(cyc);
                s = {1'b0, edge_v[i]} + {1'b0, edge_v[j]};
                chk("R5 ADD sum", mem[8'h42], s[15:0]);
                chk("R5 ADD carry via SZE", mem[8'h43], {15'd0, s[16]});
                chk("R4 AND/LDA/STA", mem[8'h44], edge_v[i] & edge_v[j]);
                chk("R8 CMA", mem[8'h45], ~(edge_v[i] & edge_v[j]));
                chk("R8 priority CLA over INC", mem[8'h46], 16'h0000);
            end
        end

        // R3: indirect load and store, pointer upper bits ignored
        for (int i = 0; i < 6; i++) begin
            hold_reset();
            poke(8'h00, 16'hA050); poke(8'h01, 16'h3051); poke(8'h02, 16'hB052);
            poke(8'h03, 16'h7001);
            poke(8'h50, 16'hF060); poke(8'h52, 16'h0070); poke(8'h60, edge_v[i] ^ 16'h5A00);
            run_prog(cyc);
            chk("R3 indirect load", mem[8'h51], edge_v[i] ^ 16'h5A00);
            chk("R3 indirect store", mem[8'h70], edge_v[i] ^ 16'h5A00);
        end

        // R6: BUN, BSA, indirect return
        hold_reset();
        poke(8'h00, 16'h4005); poke(8'h01, 16'h7001); poke(8'h05, 16'h5020);
        poke(8'h06, 16'h2030); poke(8'h07, 16'h3031); poke(8'h08, 16'h7001);
        poke(8'h21, 16'h2032); poke(8'h22, 16'h3033); poke(8'h23, 16'hC020);
        poke(8'h30, 16'h2468); poke(8'h32, 16'h1357);
        run_prog(cyc);
        chk("R6 BSA return address", mem[8'h20], 16'h0006);
        chk("R6 subroutine body", mem[8'h33], 16'h1357);
        chk("R6 return path", mem[8'h31], 16'h2468);

        // R7 ISZ and R8 SZA across the wrap point
        for (int i = 0; i < 5; i++) begin
            hold_reset();
            poke(8'h00, 16'h6040); poke(8'h01, 16'h7001); poke(8'h02, 16'h7800);
            poke(8'h03, 16'h7100); poke(8'h04, 16'h3041); poke(8'h05, 16'h7001);
            poke(8'h40, wrap_v[i]);
            run_prog(cyc);
            chk("R7 ISZ value", mem[8'h40], wrap_v[i] + 16'h1);
            chk("R7 ISZ skip", mem[8'h41], {15'd0, wrap_v[i] == 16'hFFFF});

            hold_reset();
            poke(8'h00, 16'h2040); poke(8'h01, 16'h7080); poke(8'h02, 16'h7001);
            poke(8'h03, 16'h7800); poke(8'h04, 16'h7100); poke(8'h05, 16'h3041);
            poke(8'h06, 16'h7001);
            poke(8'h40, wrap_v[i]);
            run_prog(cyc);
            chk("R8 SZA skip", mem[8'h41], {15'd0, wrap_v[i] == 16'h0000});
        end

        // R9 R11: input polling, INP, OUT, then frozen flags after HLT
        hold_reset();
        poke(8'h00, 16'h7020); poke(8'h01, 16'h4000); poke(8'h02, 16'h7010);
        poke(8'h03, 16'h3040); poke(8'h04, 16'h7008); poke(8'h05, 16'h7001);
        rst_n = 1'b1;
        repeat (40) @(negedge clk);
        chk("R9 in_flag idle", {15'd0, in_flag}, 16'd0);
        chk("R9 polling not halted", {15'd0, halted}, 16'd0);
        in_data = 8'hA5; in_load = 1'b1;
        @(negedge clk);
        in_load = 1'b0;
        chk("R9 in_flag set", {15'd0, in_flag}, 16'd1);
        wait_halt(cyc);
        chk("R9 INP into AC", mem[8'h40], 16'h00A5);
        chk("R9 out_data", {8'd0, out_data}, 16'h00A5);
        chk("R9 out_flag cleared", {15'd0, out_flag}, 16'd0);
        chk("R9 in_flag cleared", {15'd0, in_flag}, 16'd0);
        held = mem_addr;
        out_done = 1'b1; in_data = 8'h3C; in_load = 1'b1;
        @(negedge clk);
        out_done = 1'b0; in_load = 1'b0;
        repeat (10) @(negedge clk);
        chk("R11 out_flag frozen", {15'd0, out_flag}, 16'd0);
        chk("R11 in_flag frozen", {15'd0, in_flag}, 16'd0);
        chk("R11 mem_addr held", {4'd0, mem_addr}, {4'd0, held});
        chk("R11 still halted", {15'd0, halted}, 16'd1);

        // R10: interrupt taken at the check after ION (out_flag is 1 from reset)
        hold_reset();
        poke(8'h00, 16'h4010); poke(8'h01, 16'h2050); poke(8'h02, 16'h3051);
        poke(8'h03, 16'h7001); poke(8'h10, 16'h7004); poke(8'h11, 16'h7800);
        poke(8'h12, 16'h7001); poke(8'h50, 16'h5A5A);
        run_prog(cyc);
        chk("R10 saved PC", mem[8'h00], 16'h0011);
        chk("R10 handler ran", mem[8'h51], 16'h5A5A);
        chk("R10 enable cleared", {15'd0, int_en}, 16'd0);

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule